// File: doc/BRIEF.md
# Priority pin crossbar allocator

The allocator maps a fixed, ranked list of seventeen on-chip digital peripheral signals onto sixteen general-purpose pins. The pins form two 8-bit ports. Software supplies one enable bit per signal, an SPI four-wire mode bit and a 16-bit skip mask with port 1 in the upper byte. The block then works out which signal drives each pin and which pin each signal received. Signals are served from highest to lowest rank, and each one takes the lowest-numbered pin that is still free and not skipped. The UART transmit and receive pair is the exception: it is tied to two fixed pins on port 0.

Pin indices run from 0 to 15, where index = port * 8 + bit. The same numbering selects bits of the skip mask. The result is registered and has two views: a per-pin view, giving a valid flag and the driving signal index, and a per-signal view, giving a valid flag, the pin index and an overflow flag. Pins that no signal claims report invalid and stay under plain GPIO control.

Top module: `pin_xbar_alloc`

## Requirements
- R1: Signal indices rank from highest to lowest priority as follows: 0 UART TX, 1 UART RX, 2 SPI clock, 3 SPI MISO, 4 SPI MOSI, 5 SPI slave select, 6 LIN TX, 7 LIN RX, 8 comparator output, 9 comparator async output, 10 system clock output, 11/12/13 capture-compare channels 0/1/2, 14 external counter input, 15 timer 0 input, 16 timer 1 input. Each requesting signal from index 2 upward takes the lowest free pin not taken by a higher-ranked signal and not skipped.
- R2: Pins are searched in index order 0 to 15, where index = port * 8 + bit. Skip mask bit k applies to pin k, so skip bits 9:8 = 2'b11 pass over port 1 bits 0 and 1.
- R3: When enabled, UART TX always gets pin 4 and UART RX always gets pin 5, even if those skip bits are set. While the UART signal is enabled, no other signal may use its pin. While it is disabled, the pin is free to other signals unless it is skipped.
- R4: No signal other than the UART pair is ever placed on a skipped pin.
- R5: The SPI slave-select signal (index 5) requests a pin only when spi_4wire_i is 1. Otherwise its valid and overflow flags are 0.
- R6: A requesting signal that finds no free pin gets valid 0 and overflow 1. Lower-ranked signals are still allocated from the remaining pins.
- R7: A disabled signal reports valid 0, overflow 0 and pin 0. A pin that no signal claims reports valid 0 and signal index 0.
- R8: All outputs are 0 during reset and reflect the inputs present at the previous rising clock edge, a latency of exactly one cycle.
- R9: The two views agree. A signal reporting pin p implies that pin p is valid and names that signal, and every valid pin is claimed by exactly one signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_en_i | input | 17 | Per-signal enable, bit = signal index |
| spi_4wire_i | input | 1 | SPI four-wire mode, enables slave select |
| skip_i | input | 16 | Skip mask, bit = pin index (port 1 in bits 15:8) |
| pin_vld_o | output | 16 | Pin driven by a peripheral signal |
| pin_sig_o | output | 80 | Per-pin signal index, 5 bits per pin, pin p at [5p+4:5p] |
| sig_vld_o | output | 17 | Signal has a pin |
| sig_pin_o | output | 68 | Per-signal pin index, 4 bits per signal, signal s at [4s+3:4s] |
| sig_ovf_o | output | 17 | Signal requested a pin but none was left |

## Verification
The hardest state to reach is overflow in combination with skipped pins and the UART reservation. In that state a low-ranked signal fails while the pins reserved for the UART hold skip bits that must be ignored, and the signals after the failed one must still be placed correctly. The stimulus gets there in three ways. It sweeps all 256 port-0 skip patterns under every combination of UART enables and SPI mode, with every signal requesting. It adds pseudo-random dense skip and enable mixes. It applies directed vectors that starve the chain at a known signal. The per-pin view is then checked against the per-signal view for each vector.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NUM_SIG   = 17;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 2;
  localparam int UTX_SIG   = 0;
  localparam int URX_SIG   = 1;
  localparam int NSS_SIG   = 5;
  localparam int UTX_PIN   = 4;
  localparam int URX_PIN   = 5;
endpackage

// File: rtl/xbar_lsb_pick.sv
module xbar_lsb_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xbar_req_gate.sv
module xbar_req_gate #(
  parameter int NUM_SIG  = 17,
  parameter int NUM_PINS = 16,
  parameter int UTX_SIG  = 0,
  parameter int URX_SIG  = 1,
  parameter int NSS_SIG  = 5,
  parameter int UTX_PIN  = 4,
  parameter int URX_PIN  = 5
) (
  input  logic [NUM_SIG-1:0]  sig_en_i,
  input  logic                spi_4wire_i,
  input  logic [NUM_PINS-1:0] skip_i,
  output logic [NUM_SIG-1:0]  req_o,
  output logic [NUM_PINS-1:0] taken_o
);
  always_comb begin
    req_o          = sig_en_i;
    req_o[NSS_SIG] = sig_en_i[NSS_SIG] & spi_4wire_i;
    // fixed-pin signals bypass the search chain
    req_o[UTX_SIG] = 1'b0;
    req_o[URX_SIG] = 1'b0;
    taken_o        = skip_i;
    if (sig_en_i[UTX_SIG]) taken_o[UTX_PIN] = 1'b1;
    if (sig_en_i[URX_SIG]) taken_o[URX_PIN] = 1'b1;
  end
endmodule

// File: rtl/xbar_alloc_stage.sv
module xbar_alloc_stage #(
  parameter int NUM_PINS = 16,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                req_i,
  input  logic [NUM_PINS-1:0] taken_i,
  output logic                vld_o,
  output logic                ovf_o,
  output logic [PIN_W-1:0]    pin_o,
  output logic [NUM_PINS-1:0] taken_o
);
  logic             found;
  logic [PIN_W-1:0] idx;

  xbar_lsb_pick #(.N(NUM_PINS)) u_pick (
    .free_i  (~taken_i),
    .found_o (found),
    .idx_o   (idx)
  );

  always_comb begin
    vld_o   = req_i & found;
    ovf_o   = req_i & ~found;
    pin_o   = vld_o ? idx : '0;
    taken_o = taken_i;
    if (vld_o) taken_o[idx] = 1'b1;
  end
endmodule

// File: rtl/xbar_pin_map.sv
module xbar_pin_map #(
  parameter int NUM_SIG  = 17,
  parameter int NUM_PINS = 16,
  localparam int SIG_W   = $clog2(NUM_SIG),
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_SIG-1:0]        sig_vld_i,
  input  logic [NUM_SIG*PIN_W-1:0]  sig_pin_i,
  output logic [NUM_PINS-1:0]       pin_vld_o,
  output logic [NUM_PINS*SIG_W-1:0] pin_sig_o
);
  always_comb begin
    pin_vld_o = '0;
    pin_sig_o = '0;
    for (int s = 0; s < NUM_SIG; s++) begin
      if (sig_vld_i[s]) begin
        pin_vld_o[sig_pin_i[s*PIN_W +: PIN_W]] = 1'b1;
        pin_sig_o[sig_pin_i[s*PIN_W +: PIN_W]*SIG_W +: SIG_W] = SIG_W'(s);
      end
    end
  end
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_SIG_P   = NUM_SIG,
  parameter int PORT_W_P    = PORT_W,
  parameter int NUM_PORTS_P = NUM_PORTS,
  parameter int UTX_SIG_P   = UTX_SIG,
  parameter int URX_SIG_P   = URX_SIG,
  parameter int NSS_SIG_P   = NSS_SIG,
  parameter int UTX_PIN_P   = UTX_PIN,
  parameter int URX_PIN_P   = URX_PIN,
  localparam int NUM_PINS   = PORT_W_P * NUM_PORTS_P,
  localparam int SIG_W      = $clog2(NUM_SIG_P),
  localparam int PIN_W      = $clog2(NUM_PINS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SIG_P-1:0]        sig_en_i,
  input  logic                        spi_4wire_i,
  input  logic [NUM_PINS-1:0]         skip_i,
  output logic [NUM_PINS-1:0]         pin_vld_o,
  output logic [NUM_PINS*SIG_W-1:0]   pin_sig_o,
  output logic [NUM_SIG_P-1:0]        sig_vld_o,
  output logic [NUM_SIG_P*PIN_W-1:0]  sig_pin_o,
  output logic [NUM_SIG_P-1:0]        sig_ovf_o
);
  logic [NUM_SIG_P-1:0]       req;
  logic [NUM_PINS-1:0]        taken_c [NUM_SIG_P+1];
  logic [NUM_SIG_P-1:0]       vld_c, ovf_c;
  logic [NUM_SIG_P*PIN_W-1:0] pin_c;
  logic [NUM_PINS-1:0]        pvld_c;
  logic [NUM_PINS*SIG_W-1:0]  psig_c;

  xbar_req_gate #(
    .NUM_SIG (NUM_SIG_P), .NUM_PINS (NUM_PINS),
    .UTX_SIG (UTX_SIG_P), .URX_SIG (URX_SIG_P), .NSS_SIG (NSS_SIG_P),
    .UTX_PIN (UTX_PIN_P), .URX_PIN (URX_PIN_P)
  ) u_gate (
    .sig_en_i    (sig_en_i),
    .spi_4wire_i (spi_4wire_i),
    .skip_i      (skip_i),
    .req_o       (req),
    .taken_o     (taken_c[0])
  );

  // priority chain: rank g sees the pins claimed by ranks above it
  for (genvar g = 0; g < NUM_SIG_P; g++) begin : g_chain
    if (g == UTX_SIG_P || g == URX_SIG_P) begin : g_fixed
      localparam int FIX_PIN = (g == UTX_SIG_P) ? UTX_PIN_P : URX_PIN_P;
      assign vld_c[g]                = sig_en_i[g];
      assign ovf_c[g]                = 1'b0;
      assign pin_c[g*PIN_W +: PIN_W] = sig_en_i[g] ? PIN_W'(FIX_PIN) : '0;
      assign taken_c[g+1]            = taken_c[g];
    end else begin : g_search
      xbar_alloc_stage #(.NUM_PINS(NUM_PINS)) u_stage (
        .req_i   (req[g]),
        .taken_i (taken_c[g]),
        .vld_o   (vld_c[g]),
        .ovf_o   (ovf_c[g]),
        .pin_o   (pin_c[g*PIN_W +: PIN_W]),
        .taken_o (taken_c[g+1])
      );
    end
  end

  xbar_pin_map #(.NUM_SIG(NUM_SIG_P), .NUM_PINS(NUM_PINS)) u_map (
    .sig_vld_i (vld_c),
    .sig_pin_i (pin_c),
    .pin_vld_o (pvld_c),
    .pin_sig_o (psig_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_vld_o <= '0;
      pin_sig_o <= '0;
      sig_vld_o <= '0;
      sig_pin_o <= '0;
      sig_ovf_o <= '0;
    end else begin
      pin_vld_o <= pvld_c;
      pin_sig_o <= psig_c;
      sig_vld_o <= vld_c;
      sig_pin_o <= pin_c;
      sig_ovf_o <= ovf_c;
    end
  end
endmodule

// File: rtl/pin_xbar_alloc_chk.sv
module pin_xbar_alloc_chk #(
  parameter int NUM_SIG  = 17,
  parameter int NUM_PINS = 16,
  parameter int UTX_SIG  = 0,
  parameter int URX_SIG  = 1,
  parameter int NSS_SIG  = 5,
  parameter int UTX_PIN  = 4,
  parameter int URX_PIN  = 5,
  localparam int SIG_W   = $clog2(NUM_SIG),
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_SIG-1:0]          sig_en_i,
  input logic                        spi_4wire_i,
  input logic [NUM_PINS-1:0]         skip_i,
  input logic [NUM_PINS-1:0]         pin_vld_o,
  input logic [NUM_PINS*SIG_W-1:0]   pin_sig_o,
  input logic [NUM_SIG-1:0]          sig_vld_o,
  input logic [NUM_SIG*PIN_W-1:0]    sig_pin_o,
  input logic [NUM_SIG-1:0]          sig_ovf_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_uart_tx_pin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(sig_en_i[UTX_SIG]) |->
      sig_vld_o[UTX_SIG] && sig_pin_o[UTX_SIG*PIN_W +: PIN_W] == PIN_W'(UTX_PIN));

  p_uart_rx_pin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(sig_en_i[URX_SIG]) |->
      sig_vld_o[URX_SIG] && sig_pin_o[URX_SIG*PIN_W +: PIN_W] == PIN_W'(URX_PIN));

  p_nss_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(spi_4wire_i) |-> !sig_vld_o[NSS_SIG] && !sig_ovf_o[NSS_SIG]);

  p_ovf_only_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && (|sig_ovf_o) |-> &(pin_vld_o | $past(skip_i)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == UTX_PIN || p == URX_PIN) begin : g_upin
      p_uart_reserve_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(sig_en_i[(p == UTX_PIN) ? UTX_SIG : URX_SIG]) |->
          pin_vld_o[p] &&
          pin_sig_o[p*SIG_W +: SIG_W] == SIG_W'((p == UTX_PIN) ? UTX_SIG : URX_SIG));
    end else begin : g_npin
      p_skip_honoured_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(skip_i[p]) |-> !pin_vld_o[p]);
    end
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    p_vld_ovf_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sig_vld_o[s] && sig_ovf_o[s]));

    p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && !$past(sig_en_i[s]) |-> !sig_vld_o[s] && !sig_ovf_o[s]);

    p_views_agree_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_vld_o[s] |->
        pin_vld_o[sig_pin_o[s*PIN_W +: PIN_W]] &&
        pin_sig_o[sig_pin_o[s*PIN_W +: PIN_W]*SIG_W +: SIG_W] == SIG_W'(s));

    if (s != UTX_SIG && s != URX_SIG) begin : g_srch
      p_lowest_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && sig_vld_o[s] |->
          ((pin_vld_o | $past(skip_i)) &
           ((NUM_PINS'(1) << sig_pin_o[s*PIN_W +: PIN_W]) - NUM_PINS'(1))) ==
          ((NUM_PINS'(1) << sig_pin_o[s*PIN_W +: PIN_W]) - NUM_PINS'(1)));
    end
  end
endmodule

bind pin_xbar_alloc pin_xbar_alloc_chk #(
  .NUM_SIG (NUM_SIG_P), .NUM_PINS (NUM_PINS),
  .UTX_SIG (UTX_SIG_P), .URX_SIG (URX_SIG_P), .NSS_SIG (NSS_SIG_P),
  .UTX_PIN (UTX_PIN_P), .URX_PIN (URX_PIN_P)
) u_chk (.*);

// File: tb/pin_xbar_alloc_tb.sv
module pin_xbar_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 17;
  localparam int NP = 16;
  localparam int SW = 5;
  localparam int PW = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NS-1:0]    sig_en_i = '0;
  logic             spi_4wire_i = 1'b0;
  logic [NP-1:0]    skip_i = '0;
  logic [NP-1:0]    pin_vld_o;
  logic [NP*SW-1:0] pin_sig_o;
  logic [NS-1:0]    sig_vld_o;
  logic [NS*PW-1:0] sig_pin_o;
  logic [NS-1:0]    sig_ovf_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pin_xbar_alloc u_dut (.*);

  logic [NS-1:0] e_vld, e_ovf;
  int            e_pin [NS];
  logic [NP-1:0] e_pvld;
  int            e_psig [NP];

  // expected allocation from the requirements
  function automatic void model(input logic [NS-1:0] en, input logic s4, input logic [NP-1:0] sk);
    logic [NP-1:0] tk;
    tk = sk; e_vld = '0; e_ovf = '0; e_pvld = '0;
    for (int s = 0; s < NS; s++) e_pin[s] = 0;
    for (int p = 0; p < NP; p++) e_psig[p] = 0;
    if (en[0]) begin tk[4] = 1'b1; e_vld[0] = 1'b1; e_pin[0] = 4; end
    if (en[1]) begin tk[5] = 1'b1; e_vld[1] = 1'b1; e_pin[1] = 5; end
    for (int s = 2; s < NS; s++) begin
      if (en[s] && (s != 5 || s4)) begin
        bit got = 0;
        for (int p = 0; p < NP; p++)
          if (!got && !tk[p]) begin got = 1; tk[p] = 1'b1; e_vld[s] = 1'b1; e_pin[s] = p; end
        if (!got) e_ovf[s] = 1'b1;
      end
    end
    for (int s = 0; s < NS; s++)
      if (e_vld[s]) begin e_pvld[e_pin[s]] = 1'b1; e_psig[e_pin[s]] = s; end
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    if (s == 0 || s == 1) return "R3";
    if (s == 5) return "R5";
    return "R1";
  endfunction

  task automatic compare_all(input string ctx);
    for (int s = 0; s < NS; s++) begin
      int ap = int'(sig_pin_o[s*PW +: PW]);
      chk(sig_vld_o[s] == e_vld[s], tag_of(s), $sformatf("%s sig%0d vld", ctx, s), sig_vld_o[s], e_vld[s]);
      chk(ap == e_pin[s], e_vld[s] ? tag_of(s) : "R7", $sformatf("%s sig%0d pin", ctx, s), ap, e_pin[s]);
      chk(sig_ovf_o[s] == e_ovf[s], "R6", $sformatf("%s sig%0d ovf", ctx, s), sig_ovf_o[s], e_ovf[s]);
    end
    for (int p = 0; p < NP; p++) begin
      int as = int'(pin_sig_o[p*SW +: SW]);
      chk(pin_vld_o[p] == e_pvld[p] && as == e_psig[p], e_pvld[p] ? "R9" : "R7",
          $sformatf("%s pin%0d sig", ctx, p), as, e_psig[p]);
    end
    // R4: no skipped pin outside the UART pair carries a signal
    chk((pin_vld_o & skip_i & ~16'h0030) == '0, "R4", {ctx, " skipped pins"},
        int'(pin_vld_o & skip_i & ~16'h0030), 0);
  endtask

  task automatic apply(input logic [NS-1:0] en, input logic s4, input logic [NP-1:0] sk, input string ctx);
    @(negedge clk_i);
    sig_en_i = en; spi_4wire_i = s4; skip_i = sk;
    model(en, s4, sk);
    @(negedge clk_i);
    compare_all(ctx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    sig_en_i = '1; spi_4wire_i = 1'b1;
    @(negedge clk_i);
    chk(pin_vld_o == '0 && sig_vld_o == '0 && sig_ovf_o == '0 && sig_pin_o == '0 && pin_sig_o == '0,
        "R8", "outputs in reset", int'(sig_vld_o), 0);
    rst_ni = 1'b1;

    // R6: all requesting, no skips: timer 1 starves, timer 0 lands on pin 15
    apply('1, 1'b1, 16'h0000, "full");
    chk(sig_ovf_o[16] == 1'b1, "R6", "timer1 overflow", sig_ovf_o[16], 1);
    chk(int'(sig_pin_o[15*PW +: PW]) == 15, "R6", "timer0 pin", int'(sig_pin_o[15*PW +: PW]), 15);

    // R2: port 1 bits 0 and 1 skipped -> comparator output on port 1 bit 2
    apply('1, 1'b1, 16'h0300, "skip_p1");
    chk(int'(sig_pin_o[8*PW +: PW]) == 10, "R2", "comparator pin", int'(sig_pin_o[8*PW +: PW]), 10);
    chk(sig_ovf_o[14] && !sig_vld_o[14] && sig_vld_o[13], "R6", "ext counter overflow", sig_ovf_o[14], 1);

    // R3: UART off frees pins 4 and 5 for LIN
    apply(17'h1FFFC, 1'b1, 16'h0000, "uart_off");
    chk(int'(sig_pin_o[6*PW +: PW]) == 4, "R3", "LIN TX on freed pin", int'(sig_pin_o[6*PW +: PW]), 4);

    // R3: UART pins skipped but UART enabled keeps them
    apply('1, 1'b1, 16'h0030, "uart_skipped");
    chk(sig_vld_o[0] && int'(sig_pin_o[0 +: PW]) == 4, "R3", "UART TX pin", int'(sig_pin_o[0 +: PW]), 4);

    // R5: three-wire SPI leaves slave select out
    apply('1, 1'b0, 16'h0000, "spi3");
    chk(!sig_vld_o[5] && !sig_ovf_o[5], "R5", "NSS idle", sig_vld_o[5], 0);
    chk(int'(sig_pin_o[6*PW +: PW]) == 3, "R5", "LIN TX moves up", int'(sig_pin_o[6*PW +: PW]), 3);

    // R7: nothing enabled
    apply('0, 1'b1, 16'h0000, "none");
    chk(pin_vld_o == '0, "R7", "no pin driven", int'(pin_vld_o), 0);

    // R8: one-cycle latency, old result held until the edge
    apply(17'h00004, 1'b0, 16'h0000, "lat_a");
    @(negedge clk_i);
    sig_en_i = 17'h00004; skip_i = 16'h0001;
    #1;
    chk(int'(sig_pin_o[2*PW +: PW]) == 0, "R8", "held before edge", int'(sig_pin_o[2*PW +: PW]), 0);
    @(negedge clk_i);
    chk(int'(sig_pin_o[2*PW +: PW]) == 1, "R8", "updated after edge", int'(sig_pin_o[2*PW +: PW]), 1);

    // exhaustive port-0 skip sweep over UART enables and SPI mode
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 256; k++)
        apply({15'h7FFF, m[1:0]}, m[2], {8'(k ^ (k >> 3)), 8'(k)}, $sformatf("sweep m%0d k%0d", m, k));

    // pseudo-random enable and skip mixes
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < 1500; i++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      apply(NS'(lfsr ^ (lfsr >> 9)), lfsr[31], lfsr[27:12] & lfsr[20:5], $sformatf("rand %0d", i));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule